// File: doc/BRIEF.md
# Dual-Port Doorbell Mailbox Register Bank

This block joins two agents on one clock, a producer and a consumer, through two AXI4-Lite subordinate ports. Each port has a 12-bit address and a 32-bit data path. The producer owns the register set of the submission queue, and the consumer owns the register set of the completion queue. Each set holds a 32-bit tail-pointer doorbell, an interrupt word, a control word, and a 64-bit queue memory address split into a low word and a high word.

Each port can also read its peer's register set, read-only, at offset 0x100. Reads through this mirror are how an agent acknowledges the peer's doorbell: they clear that queue's interrupt. A control bit applies a soft reset to both queues at once.

The control word selects how a queue's interrupt is raised. In one mode, any write to the tail pointer raises it. In the other mode, software sets a trigger bit in the interrupt word. The interrupt line of each queue stays high until the peer acknowledges it, or until a reset clears it.

Top module: `mbx_bank`

## Requirements
- R1: While rst_n is low, and after it is released, every register of both queues reads as zero. Both interrupt outputs, bvalid and rvalid are low, and arready is high.
- R2: Each port's own set is laid out as word offsets: 0x000 tail pointer, 0x008 address bits 31:0, 0x010 address bits 63:32. These three are read/write. A write updates only the byte lanes whose wstrb bit is set.
- R3: A write is accepted (awready and wready high in the same cycle) only when awvalid and wvalid are both high and no response is pending. bvalid then stays high until bready. bresp is always 00.
- R4: A read is accepted when arvalid is high and no read data is pending. rvalid and rdata then hold until rready. rresp is always 00. Offsets that are not mapped read as zero.
- R5: At 0x100, 0x104, 0x108, 0x10C and 0x110, each port reads the peer queue's tail pointer, interrupt status (bit 0), low address, control (enable bit 0, mode bit 1) and high address. Writes to these offsets change nothing.
- R6: The interrupt word at 0x004 reads its status in bit 1 and reads bit 0 as zero. The control word at 0x00C holds enable in bit 0 and mode in bit 1, and reads bit 31 as zero.
- R7: With enable=1 and mode=0, any accepted write to the tail pointer raises the queue's interrupt on the handshake edge. A trigger write does nothing in this mode.
- R8: With enable=1 and mode=1, an accepted write to 0x004 with wdata[0]=1 and wstrb[0]=1 raises the interrupt. A tail write does not.
- R9: With enable=0, neither tail writes nor trigger writes raise the interrupt.
- R10: A peer read of mirror 0x100 clears the interrupt when the mode is 0. A peer read of 0x104 clears it when the mode is 1. The other offset leaves it set, and the data returned shows the status as it was before the clear.
- R11: An accepted write to 0x00C with wdata[31]=1 and wstrb[3]=1 clears every register of both queues and both interrupts. The other fields of that write are not stored. Without wstrb[3] set, no reset occurs.
- R12: If both ports issue the soft reset in the same cycle, both writes complete with a response and the state is cleared once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports and all state |
| rst_n | input | 1 | Active-low reset |
| prod_awaddr | input | 12 | Producer write address |
| prod_awvalid | input | 1 | Producer write address valid |
| prod_awready | output | 1 | Producer write address ready |
| prod_wdata | input | 32 | Producer write data |
| prod_wstrb | input | 4 | Producer write byte strobes |
| prod_wvalid | input | 1 | Producer write data valid |
| prod_wready | output | 1 | Producer write data ready |
| prod_bresp | output | 2 | Producer write response |
| prod_bvalid | output | 1 | Producer write response valid |
| prod_bready | input | 1 | Producer write response ready |
| prod_araddr | input | 12 | Producer read address |
| prod_arvalid | input | 1 | Producer read address valid |
| prod_arready | output | 1 | Producer read address ready |
| prod_rdata | output | 32 | Producer read data |
| prod_rresp | output | 2 | Producer read response |
| prod_rvalid | output | 1 | Producer read data valid |
| prod_rready | input | 1 | Producer read data ready |
| cons_awaddr | input | 12 | Consumer write address |
| cons_awvalid | input | 1 | Consumer write address valid |
| cons_awready | output | 1 | Consumer write address ready |
| cons_wdata | input | 32 | Consumer write data |
| cons_wstrb | input | 4 | Consumer write byte strobes |
| cons_wvalid | input | 1 | Consumer write data valid |
| cons_wready | output | 1 | Consumer write data ready |
| cons_bresp | output | 2 | Consumer write response |
| cons_bvalid | output | 1 | Consumer write response valid |
| cons_bready | input | 1 | Consumer write response ready |
| cons_araddr | input | 12 | Consumer read address |
| cons_arvalid | input | 1 | Consumer read address valid |
| cons_arready | output | 1 | Consumer read address ready |
| cons_rdata | output | 32 | Consumer read data |
| cons_rresp | output | 2 | Consumer read response |
| cons_rvalid | output | 1 | Consumer read data valid |
| cons_rready | input | 1 | Consumer read data ready |
| irq_sub | output | 1 | Submission queue interrupt |
| irq_cmp | output | 1 | Completion queue interrupt |

## Verification
Some rules hold on every cycle, and the assertions check these. They cover the AXI handshake: responses held until taken, no accept while a response is pending, write accept only with both address and data present, and OKAY responses. They also check that an interrupt can only rise right after a write on its owner's port, and can only fall right after a peer read or a write. A further assertion checks that both interrupts are low after a soft-reset write.

Other behaviour depends on register contents, so only the bench scenarios can show it. This covers which mode and enable setting lets an event through, the selection of the clearing offset by mode, byte-strobe merging, the mirror contents, ignored writes to the mirror, and reset applied from both ports in the same cycle. The bench model tracks the register contents and checks both interrupt lines on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int unsigned REG_W       = 32;
   localparam int unsigned NSLOT       = 5;
   localparam int unsigned CTL_ENA_BIT = 0;
   localparam int unsigned CTL_MOD_BIT = 1;
   localparam int unsigned CTL_RST_BIT = 31;
   localparam int unsigned INT_TRG_BIT = 0;
   localparam int unsigned INT_STA_BIT = 1;
   localparam int unsigned PEER_STA_BIT = 0;

   typedef enum logic [2:0] {
      SL_TAIL = 3'd0,
      SL_INTR = 3'd1,
      SL_ADRL = 3'd2,
      SL_CTRL = 3'd3,
      SL_ADRH = 3'd4
   } slot_e;

   typedef struct packed {
      logic [REG_W-1:0] tail;
      logic [REG_W-1:0] adr_lo;
      logic [REG_W-1:0] adr_hi;
      logic             ena;
      logic             mode;
      logic             pend;
   } qstate_t;

   function automatic logic [REG_W-1:0] merge_lanes(
      input logic [REG_W-1:0]   old_v,
      input logic [REG_W-1:0]   new_v,
      input logic [REG_W/8-1:0] strb);
      logic [REG_W-1:0] res;
      res = old_v;
      for (int b = 0; b < REG_W/8; b++) begin
         if (strb[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
      end
      return res;
   endfunction

endpackage

// File: rtl/mbx_axil_slv.sv
module mbx_axil_slv #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   awaddr,
   input  logic                awvalid,
   output logic                awready,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] wstrb,
   input  logic                wvalid,
   output logic                wready,
   output logic [1:0]          bresp,
   output logic                bvalid,
   input  logic                bready,
   input  logic [ADDR_W-1:0]   araddr,
   input  logic                arvalid,
   output logic                arready,
   output logic [DATA_W-1:0]   rdata,
   output logic [1:0]          rresp,
   output logic                rvalid,
   input  logic                rready,
   output logic                wr_fire,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W/8-1:0] wr_strb,
   output logic                rd_fire,
   output logic [ADDR_W-1:0]   rd_addr,
   input  logic [DATA_W-1:0]   rd_word
);

   localparam logic [1:0] RESP_OK = 2'b00;

   logic              b_busy;
   logic              r_busy;
   logic [DATA_W-1:0] r_hold;

   assign wr_fire = awvalid & wvalid & ~b_busy;
   assign awready = wr_fire;
   assign wready  = wr_fire;
   assign wr_addr = awaddr;
   assign wr_data = wdata;
   assign wr_strb = wstrb;

   assign rd_fire = arvalid & ~r_busy;
   assign arready = ~r_busy;
   assign rd_addr = araddr;

   assign bvalid = b_busy;
   assign bresp  = RESP_OK;
   assign rvalid = r_busy;
   assign rdata  = r_hold;
   assign rresp  = RESP_OK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_busy <= 1'b0;
      end else if (wr_fire) begin
         b_busy <= 1'b1;
      end else if (bready) begin
         b_busy <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_busy <= 1'b0;
         r_hold <= '0;
      end else if (rd_fire) begin
         r_busy <= 1'b1;
         r_hold <= rd_word;
      end else if (rready) begin
         r_busy <= 1'b0;
      end
   end

endmodule

// File: rtl/mbx_queue_regs.sv
module mbx_queue_regs
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               srst_all,
   input  logic               wr_fire,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [REG_W/8-1:0] wr_strb,
   input  logic               clr_pend,
   output qstate_t            st,
   output logic               srst_req
);

   localparam int unsigned WI = ADDR_W - 2;

   logic [WI-1:0] wsel;
   logic          in_loc;
   logic [2:0]    slot;
   logic          hit_tail, hit_intr, hit_adrl, hit_adrh, hit_ctrl;
   logic          trig, set_ev;

   always_comb begin
      wsel     = wr_addr[ADDR_W-1:2];
      in_loc   = wr_fire && (wsel < WI'(NSLOT));
      slot     = wsel[2:0];
      hit_tail = in_loc && (slot == SL_TAIL);
      hit_intr = in_loc && (slot == SL_INTR);
      hit_adrl = in_loc && (slot == SL_ADRL);
      hit_adrh = in_loc && (slot == SL_ADRH);
      hit_ctrl = in_loc && (slot == SL_CTRL);
      trig     = hit_intr && wr_strb[0] && wr_data[INT_TRG_BIT];
      srst_req = hit_ctrl && wr_strb[CTL_RST_BIT/8] && wr_data[CTL_RST_BIT];
      set_ev   = st.ena && (st.mode ? trig : hit_tail);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else if (srst_all) begin
         st <= '0;
      end else begin
         if (hit_tail) st.tail   <= merge_lanes(st.tail,   wr_data, wr_strb);
         if (hit_adrl) st.adr_lo <= merge_lanes(st.adr_lo, wr_data, wr_strb);
         if (hit_adrh) st.adr_hi <= merge_lanes(st.adr_hi, wr_data, wr_strb);
         if (hit_ctrl && wr_strb[0]) begin
            st.ena  <= wr_data[CTL_ENA_BIT];
            st.mode <= wr_data[CTL_MOD_BIT];
         end
         if (set_ev) begin
            st.pend <= 1'b1;
         end else if (clr_pend) begin
            st.pend <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mbx_view_mux.sv
module mbx_view_mux
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned MIRROR_BASE = 'h100
) (
   input  logic              rd_fire,
   input  logic [ADDR_W-1:0] rd_addr,
   input  qstate_t           own,
   input  qstate_t           peer,
   output logic [REG_W-1:0]  rd_word,
   output logic              clr_peer
);

   localparam int unsigned WI      = ADDR_W - 2;
   localparam int unsigned MIR_IDX = MIRROR_BASE / 4;

   logic [WI-1:0] rsel, moff;
   logic          in_loc, in_mir;
   logic [2:0]    slot;
   qstate_t       src;

   always_comb begin
      rsel    = rd_addr[ADDR_W-1:2];
      moff    = rsel - WI'(MIR_IDX);
      in_loc  = rsel < WI'(NSLOT);
      in_mir  = (rsel >= WI'(MIR_IDX)) && (moff < WI'(NSLOT));
      slot    = in_loc ? rsel[2:0] : moff[2:0];
      src     = in_loc ? own : peer;
      rd_word = '0;
      if (in_loc || in_mir) begin
         case (slot)
            SL_TAIL: rd_word = src.tail;
            SL_INTR: begin
               if (in_loc) rd_word[INT_STA_BIT]  = src.pend;
               else        rd_word[PEER_STA_BIT] = src.pend;
            end
            SL_ADRL: rd_word = src.adr_lo;
            SL_CTRL: begin
               rd_word[CTL_ENA_BIT] = src.ena;
               rd_word[CTL_MOD_BIT] = src.mode;
            end
            SL_ADRH: rd_word = src.adr_hi;
            default: rd_word = '0;
         endcase
      end
      clr_peer = rd_fire && in_mir &&
                 (((slot == SL_TAIL) && !peer.mode) ||
                  ((slot == SL_INTR) &&  peer.mode));
   end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MIRROR_BASE = 'h100
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   prod_awaddr,
   input  logic                prod_awvalid,
   output logic                prod_awready,
   input  logic [DATA_W-1:0]   prod_wdata,
   input  logic [DATA_W/8-1:0] prod_wstrb,
   input  logic                prod_wvalid,
   output logic                prod_wready,
   output logic [1:0]          prod_bresp,
   output logic                prod_bvalid,
   input  logic                prod_bready,
   input  logic [ADDR_W-1:0]   prod_araddr,
   input  logic                prod_arvalid,
   output logic                prod_arready,
   output logic [DATA_W-1:0]   prod_rdata,
   output logic [1:0]          prod_rresp,
   output logic                prod_rvalid,
   input  logic                prod_rready,
   input  logic [ADDR_W-1:0]   cons_awaddr,
   input  logic                cons_awvalid,
   output logic                cons_awready,
   input  logic [DATA_W-1:0]   cons_wdata,
   input  logic [DATA_W/8-1:0] cons_wstrb,
   input  logic                cons_wvalid,
   output logic                cons_wready,
   output logic [1:0]          cons_bresp,
   output logic                cons_bvalid,
   input  logic                cons_bready,
   input  logic [ADDR_W-1:0]   cons_araddr,
   input  logic                cons_arvalid,
   output logic                cons_arready,
   output logic [DATA_W-1:0]   cons_rdata,
   output logic [1:0]          cons_rresp,
   output logic                cons_rvalid,
   input  logic                cons_rready,
   output logic                irq_sub,
   output logic                irq_cmp
);

   localparam int unsigned NSIDE  = 2;
   localparam int unsigned STRB_W = DATA_W / 8;

   if (DATA_W != REG_W) begin : g_bad_width
      $error("mbx_bank: DATA_W must equal the register width");
   end
   if ((MIRROR_BASE % 4) != 0 || MIRROR_BASE < NSLOT * 4) begin : g_bad_base
      $error("mbx_bank: MIRROR_BASE must be word aligned and above the local set");
   end
   if (MIRROR_BASE + NSLOT * 4 > (1 << ADDR_W)) begin : g_bad_span
      $error("mbx_bank: mirror window does not fit the address space");
   end

   logic [ADDR_W-1:0] s_awaddr [NSIDE];
   logic              s_awvalid[NSIDE], s_awready[NSIDE];
   logic [DATA_W-1:0] s_wdata  [NSIDE];
   logic [STRB_W-1:0] s_wstrb  [NSIDE];
   logic              s_wvalid [NSIDE], s_wready [NSIDE];
   logic [1:0]        s_bresp  [NSIDE];
   logic              s_bvalid [NSIDE], s_bready [NSIDE];
   logic [ADDR_W-1:0] s_araddr [NSIDE];
   logic              s_arvalid[NSIDE], s_arready[NSIDE];
   logic [DATA_W-1:0] s_rdata  [NSIDE];
   logic [1:0]        s_rresp  [NSIDE];
   logic              s_rvalid [NSIDE], s_rready [NSIDE];

   logic              wr_fire [NSIDE];
   logic [ADDR_W-1:0] wr_addr [NSIDE];
   logic [DATA_W-1:0] wr_data [NSIDE];
   logic [STRB_W-1:0] wr_strb [NSIDE];
   logic              rd_fire [NSIDE];
   logic [ADDR_W-1:0] rd_addr [NSIDE];
   logic [DATA_W-1:0] rd_word [NSIDE];
   logic              clr_peer[NSIDE];
   logic              srst_req[NSIDE];
   qstate_t           qst     [NSIDE];
   logic              srst_all;

   assign s_awaddr[0]  = prod_awaddr;   assign s_awaddr[1]  = cons_awaddr;
   assign s_awvalid[0] = prod_awvalid;  assign s_awvalid[1] = cons_awvalid;
   assign s_wdata[0]   = prod_wdata;    assign s_wdata[1]   = cons_wdata;
   assign s_wstrb[0]   = prod_wstrb;    assign s_wstrb[1]   = cons_wstrb;
   assign s_wvalid[0]  = prod_wvalid;   assign s_wvalid[1]  = cons_wvalid;
   assign s_bready[0]  = prod_bready;   assign s_bready[1]  = cons_bready;
   assign s_araddr[0]  = prod_araddr;   assign s_araddr[1]  = cons_araddr;
   assign s_arvalid[0] = prod_arvalid;  assign s_arvalid[1] = cons_arvalid;
   assign s_rready[0]  = prod_rready;   assign s_rready[1]  = cons_rready;

   assign prod_awready = s_awready[0];  assign cons_awready = s_awready[1];
   assign prod_wready  = s_wready[0];   assign cons_wready  = s_wready[1];
   assign prod_bresp   = s_bresp[0];    assign cons_bresp   = s_bresp[1];
   assign prod_bvalid  = s_bvalid[0];   assign cons_bvalid  = s_bvalid[1];
   assign prod_arready = s_arready[0];  assign cons_arready = s_arready[1];
   assign prod_rdata   = s_rdata[0];    assign cons_rdata   = s_rdata[1];
   assign prod_rresp   = s_rresp[0];    assign cons_rresp   = s_rresp[1];
   assign prod_rvalid  = s_rvalid[0];   assign cons_rvalid  = s_rvalid[1];

   assign srst_all = srst_req[0] | srst_req[1];
   assign irq_sub  = qst[0].pend;
   assign irq_cmp  = qst[1].pend;

   for (genvar g = 0; g < NSIDE; g++) begin : g_side
      localparam int unsigned PEER = NSIDE - 1 - g;

      mbx_axil_slv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
         .clk     (clk),          .rst_n   (rst_n),
         .awaddr  (s_awaddr[g]),  .awvalid (s_awvalid[g]), .awready (s_awready[g]),
         .wdata   (s_wdata[g]),   .wstrb   (s_wstrb[g]),   .wvalid  (s_wvalid[g]),
         .wready  (s_wready[g]),  .bresp   (s_bresp[g]),   .bvalid  (s_bvalid[g]),
         .bready  (s_bready[g]),  .araddr  (s_araddr[g]),  .arvalid (s_arvalid[g]),
         .arready (s_arready[g]), .rdata   (s_rdata[g]),   .rresp   (s_rresp[g]),
         .rvalid  (s_rvalid[g]),  .rready  (s_rready[g]),
         .wr_fire (wr_fire[g]),   .wr_addr (wr_addr[g]),   .wr_data (wr_data[g]),
         .wr_strb (wr_strb[g]),   .rd_fire (rd_fire[g]),   .rd_addr (rd_addr[g]),
         .rd_word (rd_word[g])
      );

      mbx_queue_regs #(.ADDR_W(ADDR_W)) u_queue (
         .clk      (clk),
         .rst_n    (rst_n),
         .srst_all (srst_all),
         .wr_fire  (wr_fire[g]),
         .wr_addr  (wr_addr[g]),
         .wr_data  (wr_data[g]),
         .wr_strb  (wr_strb[g]),
         .clr_pend (clr_peer[PEER]),
         .st       (qst[g]),
         .srst_req (srst_req[g])
      );

      mbx_view_mux #(.ADDR_W(ADDR_W), .MIRROR_BASE(MIRROR_BASE)) u_view (
         .rd_fire  (rd_fire[g]),
         .rd_addr  (rd_addr[g]),
         .own      (qst[g]),
         .peer     (qst[PEER]),
         .rd_word  (rd_word[g]),
         .clr_peer (clr_peer[g])
      );
   end

endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   prod_awaddr,
   input logic                prod_awvalid,
   input logic                prod_awready,
   input logic [DATA_W-1:0]   prod_wdata,
   input logic [DATA_W/8-1:0] prod_wstrb,
   input logic                prod_wvalid,
   input logic [1:0]          prod_bresp,
   input logic                prod_bvalid,
   input logic                prod_bready,
   input logic                prod_arvalid,
   input logic                prod_arready,
   input logic [DATA_W-1:0]   prod_rdata,
   input logic [1:0]          prod_rresp,
   input logic                prod_rvalid,
   input logic                prod_rready,
   input logic [ADDR_W-1:0]   cons_awaddr,
   input logic                cons_awvalid,
   input logic                cons_awready,
   input logic [DATA_W-1:0]   cons_wdata,
   input logic [DATA_W/8-1:0] cons_wstrb,
   input logic                cons_wvalid,
   input logic [1:0]          cons_bresp,
   input logic                cons_bvalid,
   input logic                cons_bready,
   input logic                cons_arvalid,
   input logic                cons_arready,
   input logic [DATA_W-1:0]   cons_rdata,
   input logic [1:0]          cons_rresp,
   input logic                cons_rvalid,
   input logic                cons_rready,
   input logic                irq_sub,
   input logic                irq_cmp
);

   localparam int unsigned WI = ADDR_W - 2;

   logic p_wr, c_wr, p_srst, c_srst;
   assign p_wr   = prod_awvalid && prod_awready;
   assign c_wr   = cons_awvalid && cons_awready;
   assign p_srst = p_wr && (prod_awaddr[ADDR_W-1:2] == WI'(3)) && prod_wstrb[3] && prod_wdata[31];
   assign c_srst = c_wr && (cons_awaddr[ADDR_W-1:2] == WI'(3)) && cons_wstrb[3] && cons_wdata[31];

   AST_P_BHOLD:   assert property (@(posedge clk) disable iff (!rst_n) prod_bvalid && !prod_bready |=> prod_bvalid); // R3
   AST_C_BHOLD:   assert property (@(posedge clk) disable iff (!rst_n) cons_bvalid && !cons_bready |=> cons_bvalid); // R3
   AST_P_NO_AW_B: assert property (@(posedge clk) disable iff (!rst_n) prod_bvalid |-> !prod_awready); // R3
   AST_C_NO_AW_B: assert property (@(posedge clk) disable iff (!rst_n) cons_bvalid |-> !cons_awready); // R3
   AST_P_AW_W:    assert property (@(posedge clk) disable iff (!rst_n) prod_awready |-> prod_awvalid && prod_wvalid); // R3
   AST_C_AW_W:    assert property (@(posedge clk) disable iff (!rst_n) cons_awready |-> cons_awvalid && cons_wvalid); // R3
   AST_P_RHOLD:   assert property (@(posedge clk) disable iff (!rst_n) prod_rvalid && !prod_rready |=> prod_rvalid && $stable(prod_rdata)); // R4
   AST_C_RHOLD:   assert property (@(posedge clk) disable iff (!rst_n) cons_rvalid && !cons_rready |=> cons_rvalid && $stable(cons_rdata)); // R4
   AST_P_NO_AR_R: assert property (@(posedge clk) disable iff (!rst_n) prod_rvalid |-> !prod_arready); // R4
   AST_C_NO_AR_R: assert property (@(posedge clk) disable iff (!rst_n) cons_rvalid |-> !cons_arready); // R4
   AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n) (prod_bresp == 2'b00) && (prod_rresp == 2'b00) && (cons_bresp == 2'b00) && (cons_rresp == 2'b00)); // R4
   AST_SUB_RISE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_sub) |-> $past(p_wr)); // R7
   AST_CMP_RISE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_cmp) |-> $past(c_wr)); // R8
   AST_SUB_FALL:  assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_sub) |-> $past((cons_arvalid && cons_arready) || p_wr || c_wr)); // R10
   AST_CMP_FALL:  assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_cmp) |-> $past((prod_arvalid && prod_arready) || p_wr || c_wr)); // R10
   AST_SRST_CLR:  assert property (@(posedge clk) disable iff (!rst_n) $past(p_srst || c_srst) |-> !irq_sub && !irq_cmp); // R11

endmodule

bind mbx_bank mbx_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .prod_awaddr(prod_awaddr), .prod_awvalid(prod_awvalid), .prod_awready(prod_awready),
   .prod_wdata(prod_wdata), .prod_wstrb(prod_wstrb), .prod_wvalid(prod_wvalid),
   .prod_bresp(prod_bresp), .prod_bvalid(prod_bvalid), .prod_bready(prod_bready),
   .prod_arvalid(prod_arvalid), .prod_arready(prod_arready), .prod_rdata(prod_rdata),
   .prod_rresp(prod_rresp), .prod_rvalid(prod_rvalid), .prod_rready(prod_rready),
   .cons_awaddr(cons_awaddr), .cons_awvalid(cons_awvalid), .cons_awready(cons_awready),
   .cons_wdata(cons_wdata), .cons_wstrb(cons_wstrb), .cons_wvalid(cons_wvalid),
   .cons_bresp(cons_bresp), .cons_bvalid(cons_bvalid), .cons_bready(cons_bready),
   .cons_arvalid(cons_arvalid), .cons_arready(cons_arready), .cons_rdata(cons_rdata),
   .cons_rresp(cons_rresp), .cons_rvalid(cons_rvalid), .cons_rready(cons_rready),
   .irq_sub(irq_sub), .irq_cmp(irq_cmp)
);

// File: tb/mbx_bank_bench.sv
module mbx_bank_bench;

   localparam int CLK_NS = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic [11:0] awaddr [2];
   logic        awvalid[2], awready[2];
   logic [31:0] wdata  [2];
   logic [3:0]  wstrb  [2];
   logic        wvalid [2], wready [2];
   logic [1:0]  bresp  [2];
   logic        bvalid [2], bready [2];
   logic [11:0] araddr [2];
   logic        arvalid[2], arready[2];
   logic [31:0] rdata  [2];
   logic [1:0]  rresp  [2];
   logic        rvalid [2], rready [2];
   logic        irq_sub, irq_cmp;

   int  nchk = 0;
   int  nerr = 0;
   bit  run_cmp = 1'b0;
   bit  done = 1'b0;

   logic [31:0] m_tail[2], m_lo[2], m_hi[2];
   bit          m_ie[2], m_ty[2], m_pend[2];

   always #(CLK_NS/2) clk = ~clk;

   mbx_bank u_mbx_bank (
      .clk(clk), .rst_n(rst_n),
      .prod_awaddr(awaddr[0]), .prod_awvalid(awvalid[0]), .prod_awready(awready[0]),
      .prod_wdata(wdata[0]), .prod_wstrb(wstrb[0]), .prod_wvalid(wvalid[0]),
      .prod_wready(wready[0]), .prod_bresp(bresp[0]), .prod_bvalid(bvalid[0]),
      .prod_bready(bready[0]), .prod_araddr(araddr[0]), .prod_arvalid(arvalid[0]),
      .prod_arready(arready[0]), .prod_rdata(rdata[0]), .prod_rresp(rresp[0]),
      .prod_rvalid(rvalid[0]), .prod_rready(rready[0]),
      .cons_awaddr(awaddr[1]), .cons_awvalid(awvalid[1]), .cons_awready(awready[1]),
      .cons_wdata(wdata[1]), .cons_wstrb(wstrb[1]), .cons_wvalid(wvalid[1]),
      .cons_wready(wready[1]), .cons_bresp(bresp[1]), .cons_bvalid(bvalid[1]),
      .cons_bready(bready[1]), .cons_araddr(araddr[1]), .cons_arvalid(arvalid[1]),
      .cons_arready(arready[1]), .cons_rdata(rdata[1]), .cons_rresp(rresp[1]),
      .cons_rvalid(rvalid[1]), .cons_rready(rready[1]),
      .irq_sub(irq_sub), .irq_cmp(irq_cmp)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%08h exp=%08h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic void mdl_reset();
      for (int s = 0; s < 2; s++) begin
         m_tail[s] = '0; m_lo[s] = '0; m_hi[s] = '0;
         m_ie[s] = 0; m_ty[s] = 0; m_pend[s] = 0;
      end
   endfunction

   function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n, input logic [3:0] st);
      logic [31:0] r = o;
      for (int b = 0; b < 4; b++) if (st[b]) r[b*8 +: 8] = n[b*8 +: 8];
      return r;
   endfunction

   function automatic void mdl_write(input int s, input logic [11:0] a, input logic [31:0] d, input logic [3:0] st);
      int w = int'(a >> 2);
      bit ev = 0;
      if (w == 3 && st[3] && d[31]) begin
         mdl_reset();
         return;
      end
      if (w == 0) ev = m_ie[s] && !m_ty[s];
      if (w == 1) ev = m_ie[s] && m_ty[s] && st[0] && d[0];
      case (w)
         0: m_tail[s] = lanes(m_tail[s], d, st);
         2: m_lo[s]   = lanes(m_lo[s], d, st);
         4: m_hi[s]   = lanes(m_hi[s], d, st);
         3: if (st[0]) begin m_ie[s] = d[0]; m_ty[s] = d[1]; end
         default: ;
      endcase
      if (ev) m_pend[s] = 1;
   endfunction

   function automatic logic [31:0] mdl_read(input int s, input logic [11:0] a);
      int w = int'(a >> 2);
      int p = 1 - s;
      logic [31:0] r = '0;
      case (w)
         0:  r = m_tail[s];
         1:  r[1] = m_pend[s];
         2:  r = m_lo[s];
         3:  r[1:0] = {m_ty[s], m_ie[s]};
         4:  r = m_hi[s];
         64: begin r = m_tail[p]; if (!m_ty[p]) m_pend[p] = 0; end
         65: begin r[0] = m_pend[p]; if (m_ty[p]) m_pend[p] = 0; end
         66: r = m_lo[p];
         67: r[1:0] = {m_ty[p], m_ie[p]};
         68: r = m_hi[p];
         default: r = '0;
      endcase
      return r;
   endfunction

   always @(negedge clk) begin
      if (run_cmp) begin
         chk(irq_sub === m_pend[0], "R7 irq_sub vs model", 32'(irq_sub), 32'(m_pend[0]));
         chk(irq_cmp === m_pend[1], "R8 irq_cmp vs model", 32'(irq_cmp), 32'(m_pend[1]));
      end
   end

   task automatic do_wr(input int s, input logic [11:0] a, input logic [31:0] d, input logic [3:0] st, input int bhold);
      @(negedge clk);
      awaddr[s] = a; wdata[s] = d; wstrb[s] = st;
      awvalid[s] = 1; wvalid[s] = 1; bready[s] = (bhold == 0);
      #1;
      while (!awready[s]) begin @(negedge clk); #1; end
      @(posedge clk);
      mdl_write(s, a, d, st);
      @(negedge clk);
      awvalid[s] = 0; wvalid[s] = 0;
      #1;
      chk(bvalid[s] === 1'b1 && bresp[s] === 2'b00, "R3 response after write", {bresp[s], 29'd0, bvalid[s]}, 32'd1);
      for (int k = 0; k < bhold; k++) begin
         @(negedge clk); #1;
         chk(bvalid[s] === 1'b1, "R3 bvalid held", 32'(bvalid[s]), 32'd1);
      end
      bready[s] = 1;
      @(negedge clk); #1;
      chk(bvalid[s] === 1'b0, "R3 bvalid dropped", 32'(bvalid[s]), 32'd0);
   endtask

   task automatic do_rd(input int s, input logic [11:0] a, input int rhold, output logic [31:0] d);
      logic [31:0] exp;
      @(negedge clk);
      araddr[s] = a; arvalid[s] = 1; rready[s] = (rhold == 0);
      #1;
      while (!arready[s]) begin @(negedge clk); #1; end
      @(posedge clk);
      exp = mdl_read(s, a);
      @(negedge clk);
      arvalid[s] = 0;
      #1;
      d = rdata[s];
      chk(rvalid[s] === 1'b1 && rresp[s] === 2'b00, "R4 read valid", {rresp[s], 29'd0, rvalid[s]}, 32'd1);
      chk(rdata[s] === exp, "R5 read data vs model", rdata[s], exp);
      for (int k = 0; k < rhold; k++) begin
         @(negedge clk); #1;
         chk(rvalid[s] === 1'b1 && rdata[s] === exp && arready[s] === 1'b0, "R4 read held", rdata[s], exp);
      end
      rready[s] = 1;
      @(negedge clk); #1;
      chk(rvalid[s] === 1'b0, "R4 rvalid dropped", 32'(rvalid[s]), 32'd0);
   endtask

   initial begin
      #(CLK_NS * 60000);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      for (int s = 0; s < 2; s++) begin
         awaddr[s] = '0; awvalid[s] = 0; wdata[s] = '0; wstrb[s] = '0; wvalid[s] = 0;
         bready[s] = 1; araddr[s] = '0; arvalid[s] = 0; rready[s] = 1;
      end
      mdl_reset();
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R1 reset state
      for (int s = 0; s < 2; s++) begin
         chk(!bvalid[s] && !rvalid[s] && arready[s], "R1 handshake idle", {bvalid[s], rvalid[s], arready[s]}, 32'b001);
      end
      chk(!irq_sub && !irq_cmp, "R1 irqs low", {irq_sub, irq_cmp}, 32'd0);
      run_cmp = 1;
      for (int s = 0; s < 2; s++) begin
         for (int w = 0; w < 5; w++) begin
            do_rd(s, 12'(w * 4), 0, rd);
            chk(rd === 32'd0, "R1 reset value", rd, 32'd0);
         end
      end

      // R2 byte strobes
      do_wr(0, 12'h000, 32'h1122_3344, 4'hF, 0);
      do_wr(0, 12'h000, 32'hAABB_CCDD, 4'h2, 0);
      do_rd(0, 12'h000, 0, rd);
      chk(rd === 32'h1122_CC44, "R2 strobed tail", rd, 32'h1122_CC44);
      do_wr(1, 12'h008, 32'h5566_7788, 4'hF, 0);
      do_wr(1, 12'h010, 32'h0000_00FF, 4'h9, 0);
      do_rd(1, 12'h010, 0, rd);
      chk(rd === 32'h0000_00FF, "R2 high address", rd, 32'h0000_00FF);

      // R5 mirror view and ignored mirror writes
      do_rd(0, 12'h108, 0, rd);
      chk(rd === 32'h5566_7788, "R5 mirror low address", rd, 32'h5566_7788);
      do_wr(1, 12'h108, 32'hDEAD_BEEF, 4'hF, 0);
      do_rd(0, 12'h008, 0, rd);
      chk(rd === 32'h0, "R5 mirror write ignored", rd, 32'h0);
      do_rd(1, 12'h108, 0, rd);

      // R4 unmapped offsets, held read data
      do_rd(0, 12'h020, 0, rd);
      chk(rd === 32'h0, "R4 unmapped read", rd, 32'h0);
      do_rd(1, 12'h200, 0, rd);
      do_rd(1, 12'h100, 3, rd);

      // R3 address without data is not accepted, held response
      @(negedge clk);
      awaddr[0] = 12'h008; wdata[0] = 32'hCAFE_0001; wstrb[0] = 4'hF; awvalid[0] = 1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         chk(!awready[0] && !wready[0], "R3 waits for data", {awready[0], wready[0]}, 32'd0);
      end
      awvalid[0] = 0;
      do_rd(0, 12'h008, 0, rd);
      chk(rd === 32'h0, "R3 no write without data", rd, 32'h0);
      do_wr(0, 12'h008, 32'hCAFE_0002, 4'hF, 3);

      // R6 interrupt word and control layout; R9 disabled
      do_wr(0, 12'h004, 32'hFFFF_FFFF, 4'hF, 0);
      chk(!irq_sub, "R9 trigger while disabled", 32'(irq_sub), 32'd0);
      do_wr(0, 12'h00C, 32'h0000_0002, 4'hF, 0);
      do_wr(0, 12'h004, 32'h0000_0001, 4'h1, 0);
      chk(!irq_sub, "R9 mode1 trigger disabled", 32'(irq_sub), 32'd0);
      do_rd(0, 12'h00C, 0, rd);
      chk(rd === 32'h2, "R6 control readback", rd, 32'h2);
      do_wr(0, 12'h00C, 32'h0000_0000, 4'hF, 0);
      do_wr(0, 12'h000, 32'h0000_0007, 4'hF, 0);
      chk(!irq_sub, "R9 tail write disabled", 32'(irq_sub), 32'd0);

      // R7 mode 0 doorbell, R10 clear via mirror tail read
      do_wr(0, 12'h00C, 32'h0000_0001, 4'h1, 0);
      do_wr(0, 12'h004, 32'h0000_0001, 4'h1, 0);
      chk(!irq_sub, "R7 trigger ignored in mode 0", 32'(irq_sub), 32'd0);
      do_wr(0, 12'h000, 32'h0000_0010, 4'hF, 0);
      chk(irq_sub, "R7 doorbell raises", 32'(irq_sub), 32'd1);
      do_rd(0, 12'h004, 0, rd);
      chk(rd === 32'h2, "R6 status bit 1, trigger bit 0", rd, 32'h2);
      do_rd(1, 12'h104, 0, rd);
      chk(rd === 32'h1 && irq_sub, "R10 status read keeps mode0 irq", rd, 32'h1);
      do_rd(1, 12'h100, 0, rd);
      chk(rd === 32'h10 && !irq_sub, "R10 tail mirror clears", rd, 32'h10);

      // R8 mode 1 trigger, R10 clear via mirror status read
      do_wr(1, 12'h00C, 32'h0000_0003, 4'h1, 0);
      do_wr(1, 12'h000, 32'h0000_0004, 4'hF, 0);
      chk(!irq_cmp, "R8 tail write ignored in mode 1", 32'(irq_cmp), 32'd0);
      do_wr(1, 12'h004, 32'h0000_0001, 4'h1, 0);
      chk(irq_cmp, "R8 trigger raises", 32'(irq_cmp), 32'd1);
      do_rd(0, 12'h100, 0, rd);
      chk(irq_cmp, "R10 tail read keeps mode1 irq", 32'(irq_cmp), 32'd1);
      do_rd(0, 12'h10C, 0, rd);
      chk(rd === 32'h3, "R5 mirror control", rd, 32'h3);
      do_rd(0, 12'h104, 0, rd);
      chk(rd === 32'h1 && !irq_cmp, "R10 status mirror clears", rd, 32'h1);

      // R11 soft reset
      do_wr(0, 12'h000, 32'h0000_0020, 4'hF, 0);
      do_wr(1, 12'h004, 32'h0000_0001, 4'h1, 0);
      do_wr(1, 12'h00C, 32'h8000_0003, 4'h7, 0);
      do_rd(0, 12'h000, 0, rd);
      chk(rd === 32'h20, "R11 no reset without lane 3", rd, 32'h20);
      do_wr(1, 12'h00C, 32'h8000_0003, 4'hF, 0);
      chk(!irq_sub && !irq_cmp, "R11 irqs cleared", {irq_sub, irq_cmp}, 32'd0);
      do_rd(0, 12'h000, 0, rd);
      chk(rd === 32'h0, "R11 tail cleared", rd, 32'h0);
      do_rd(1, 12'h00C, 0, rd);
      chk(rd === 32'h0, "R11 control cleared, bit 31 reads 0", rd, 32'h0);
      do_rd(0, 12'h008, 0, rd);

      // R12 simultaneous soft reset
      do_wr(0, 12'h010, 32'h0000_ABCD, 4'hF, 0);
      do_wr(1, 12'h000, 32'h0000_1234, 4'hF, 0);
      fork
         do_wr(0, 12'h00C, 32'h8000_0000, 4'h8, 0);
         do_wr(1, 12'h00C, 32'h8000_0000, 4'h8, 0);
      join
      do_rd(0, 12'h010, 0, rd);
      chk(rd === 32'h0, "R12 producer state cleared", rd, 32'h0);
      do_rd(1, 12'h000, 0, rd);
      chk(rd === 32'h0, "R12 consumer state cleared", rd, 32'h0);

      repeat (3) @(negedge clk);
      run_cmp = 0;
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule